// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Detector

This block holds the interrupt and output configuration for a small bank of general-purpose pins and turns each pin's (already debounced) input level into a sticky interrupt status bit and a sticky wake status bit. Every pin has one configuration word. It selects edge or level sensing, the active polarity or edge, the interrupt enable, the interrupt mask, the wake enable and the output drive. It also stores pull and drive-strength settings that have no logic effect.

A pin raises its request line when its interrupt status is set and both its enable and unmask bits are 1. The bank request is the OR of all pin requests. Software clears status by writing the word it read back: a 1 in a status position clears that bit. No separate acknowledge step exists. A trigger event that arrives in the same cycle as a clear wins, so no event is lost.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration field and both status bits of every pin are 0, so `irq`, `irq_vec`, `pend_vec`, `pad_oe` and `pad_out` are 0.
- R2: Configuration word layout: bit 0 is the mode (1 = level, 0 = edge), bits 2:1 the trigger select, bit 3 the interrupt enable, bit 4 the unmask bit, bit 5 the wake enable, bit 6 the output enable, bit 7 the output value, bits 9:8 pull, bits 11:10 drive strength, bit 12 the pin status (read only), bit 13 the interrupt status and bit 14 the wake status. Bit 15 reads 0. A write takes effect at the next clock edge.
- R3: In edge mode, trigger select 01 detects a rising input, 00 a falling input and 10 either edge, and 11 detects nothing. An input change seen at a clock edge sets the status at that edge.
- R4: In level mode, trigger select 01 is active while the input is 1 and 00 is active while it is 0. Select values 10 and 11 are never active. The status is set in every cycle the level is active, so a clear only takes effect once the level is inactive.
- R5: The interrupt status is set only when the interrupt enable is 1. With the enable at 0 a trigger leaves the interrupt status unchanged.
- R6: `irq_vec[i]` is 1 exactly when pin i has interrupt status, enable and unmask all at 1. `irq` is the OR of `irq_vec`.
- R7: Writing 1 to bit 13 clears the interrupt status and writing 1 to bit 14 clears the wake status. Writing 0 to either leaves it unchanged.
- R8: If a trigger sets a status bit in the same cycle that a write clears it, the bit stays 1.
- R9: The wake status is set by a trigger when the wake enable is 1, independent of the interrupt enable. `pend_vec[i]` is the OR of pin i's interrupt status and wake status.
- R10: `pad_oe[i]` and `pad_out[i]` follow the output-enable and output-value bits. Read bit 12 shows `pad_in[i]` while the output is disabled and the output value while it is enabled.
- R11: Pull and drive-strength fields read back as written and change no output other than `rd_data`.
- R12: A write addresses only the pin selected by `wr_sel`. All other pins keep their configuration and status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_PINS | Debounced input level per pin |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_sel | input | SEL_W | Pin addressed by a write |
| wr_data | input | WORD_W | Configuration word; a 1 in a status bit clears that bit |
| rd_sel | input | SEL_W | Pin whose word appears on `rd_data` |
| rd_data | output | WORD_W | Configuration and status word of the selected pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pad_out | output | NUM_PINS | Output value per pin |
| irq_vec | output | NUM_PINS | Request per pin (status, enable and unmask all set) |
| pend_vec | output | NUM_PINS | Interrupt or wake status per pin |
| irq | output | 1 | OR of all pin requests |

## Verification
Directed sequences drive rising and falling inputs under each edge select and show that only the chosen direction sets the status. They hold an input at its active and inactive levels in level mode, so a clear is shown to fail while the level is active and to succeed once it is not. Other sequences line a clear write up with a fresh edge in the same cycle, and set wake without interrupt enable so that the pending and request outputs come apart. A long random run with a fixed seed mixes input toggling with random configuration writes to random pins. Its reference model checks every request, pending, pad and read-back bit in every cycle, and the random writes to other pins expose any leakage between pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W   = 16;
    localparam int CFG_W    = 12;

    localparam int B_OE     = 6;
    localparam int B_OVAL   = 7;
    localparam int B_PINSTS = 12;
    localparam int B_ISTS   = 13;
    localparam int B_WSTS   = 14;

    typedef enum logic [1:0] {
        TRG_LOW_FALL  = 2'b00,
        TRG_HIGH_RISE = 2'b01,
        TRG_BOTH      = 2'b10,
        TRG_NONE      = 2'b11
    } trg_sel_e;

    // Packed so that bit positions match the configuration word
    typedef struct packed {
        logic [1:0] drv;
        logic [1:0] pull;
        logic       oval;
        logic       oen;
        logic       wake_en;
        logic       unmask;
        logic       int_en;
        trg_sel_e   trg;
        logic       level;
    } pin_cfg_t;

    function automatic pin_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        return pin_cfg_t'(w[CFG_W-1:0]);
    endfunction

endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    output pin_cfg_t          cfg_o,
    output logic              clr_int_o,
    output logic              clr_wake_o
);

    typedef struct packed {
        pin_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cfg = word_to_cfg(data_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o      = st_q.cfg;
    assign clr_int_o  = wr_i && data_i[B_ISTS];
    assign clr_wake_o = wr_i && data_i[B_WSTS];

    // R12: configuration only changes on an addressed write
    a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.cfg));

endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     din_i,
    input  pin_cfg_t cfg_i,
    input  logic     clr_int_i,
    input  logic     clr_wake_i,
    output logic     int_sts_o,
    output logic     wake_sts_o,
    output logic     irq_o
);

    typedef struct packed {
        logic prev;
        logic ists;
        logic wsts;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic rise, fall, hit;

    always_comb begin
        rise = din_i && !st_q.prev;
        fall = !din_i && st_q.prev;
        case (cfg_i.trg)
            TRG_LOW_FALL:  hit = cfg_i.level ? !din_i : fall;
            TRG_HIGH_RISE: hit = cfg_i.level ? din_i  : rise;
            TRG_BOTH:      hit = cfg_i.level ? 1'b0   : (rise || fall);
            default:       hit = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = din_i;
        // a new trigger outranks a clear in the same cycle
        st_d.ists = (cfg_i.int_en && hit) || (st_q.ists && !clr_int_i);
        st_d.wsts = (cfg_i.wake_en && hit) || (st_q.wsts && !clr_wake_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_sts_o  = st_q.ists;
    assign wake_sts_o = st_q.wsts;
    assign irq_o      = st_q.ists && cfg_i.int_en && cfg_i.unmask;

    // R3: an enabled rising edge under select 01 latches the status
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.level && cfg_i.trg == TRG_HIGH_RISE && cfg_i.int_en
         && din_i && !st_q.prev) |=> st_q.ists);

    // R5: without enable the interrupt status cannot rise
    a_r5_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.int_en && !st_q.ists) |=> !st_q.ists);

    // R7: a clear without a trigger empties the status
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int_i && !hit) |=> !st_q.ists);

    // R8: trigger and clear together leave the status set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_i.int_en && clr_int_i) |=> st_q.ists);

    // R9: wake status stays clear without wake enable
    a_r9_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.wake_en && !st_q.wsts) |=> !st_q.wsts);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] irq_vec,
    output logic [NUM_PINS-1:0] pend_vec,
    output logic                irq
);

    pin_cfg_t          cfg_w   [NUM_PINS];
    logic [WORD_W-1:0] word_w  [NUM_PINS];
    logic [NUM_PINS-1:0] ists_w, wsts_w;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel_wr, clr_i, clr_w;

        assign sel_wr = wr_en && (wr_sel == SEL_W'(p));

        gpio_pin_cfg u_cfg (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (sel_wr),
            .data_i     (wr_data),
            .cfg_o      (cfg_w[p]),
            .clr_int_o  (clr_i),
            .clr_wake_o (clr_w)
        );

        gpio_pin_trig u_trig (
            .clk        (clk),
            .rst_n      (rst_n),
            .din_i      (pad_in[p]),
            .cfg_i      (cfg_w[p]),
            .clr_int_i  (clr_i),
            .clr_wake_i (clr_w),
            .int_sts_o  (ists_w[p]),
            .wake_sts_o (wsts_w[p]),
            .irq_o      (irq_vec[p])
        );

        always_comb begin
            word_w[p]           = '0;
            word_w[p][CFG_W-1:0] = cfg_w[p];
            word_w[p][B_PINSTS] = cfg_w[p].oen ? cfg_w[p].oval : pad_in[p];
            word_w[p][B_ISTS]   = ists_w[p];
            word_w[p][B_WSTS]   = wsts_w[p];
        end

        assign pad_oe[p]   = cfg_w[p].oen;
        assign pad_out[p]  = cfg_w[p].oval;
        assign pend_vec[p] = ists_w[p] || wsts_w[p];
    end

    assign rd_data = word_w[rd_sel];
    assign irq     = |irq_vec;

    // R10: pad drive only moves after a write
    a_r10_pad_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

    // R6: a request implies the pin is pending
    a_r6_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & ~pend_vec) == '0);

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [N-1:0] pad_oe, pad_out, irq_vec, pend_vec;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [11:0] m_cfg [N];
    logic [N-1:0] m_is, m_ws, m_prev, m_pad;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(N)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .pad_oe(pad_oe), .pad_out(pad_out),
        .irq_vec(irq_vec), .pend_vec(pend_vec), .irq(irq)
    );

    function automatic logic trig_hit(input logic lvl, input logic [1:0] sel,
                                      input logic din, input logic prv);
        case (sel)
            2'b00: return lvl ? !din : (!din && prv);
            2'b01: return lvl ? din : (din && !prv);
            2'b10: return lvl ? 1'b0 : (din != prv);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] exp_word(input int i);
        logic [15:0] w;
        w = {4'b0, m_cfg[i]};
        w[12] = m_cfg[i][6] ? m_cfg[i][7] : m_pad[i];
        w[13] = m_is[i];
        w[14] = m_ws[i];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_cfg[i] = '0;
        m_is = '0; m_ws = '0; m_prev = '0; m_pad = '0;
    endtask

    task automatic check_all();
        logic [N-1:0] ev_irq, ev_pend, ev_oe, ev_out;
        for (int i = 0; i < N; i++) begin
            ev_irq[i]  = m_is[i] && m_cfg[i][3] && m_cfg[i][4];
            ev_pend[i] = m_is[i] || m_ws[i];
            ev_oe[i]   = m_cfg[i][6];
            ev_out[i]  = m_cfg[i][7];
        end
        chk("R6 irq_vec", 32'(irq_vec), 32'(ev_irq));
        chk("R6 irq", 32'(irq), 32'(|ev_irq));
        chk("R9 pend_vec", 32'(pend_vec), 32'(ev_pend));
        chk("R10 pad_oe", 32'(pad_oe), 32'(ev_oe));
        chk("R10 pad_out", 32'(pad_out), 32'(ev_out));
        chk("R2 rd_data", 32'(rd_data), 32'(exp_word(int'(rd_sel))));
    endtask

    // one clock: drive at negedge, advance the model, check at next negedge
    task automatic cyc(input logic [N-1:0] pad, input logic we, input logic [1:0] sel,
                       input logic [15:0] data, input logic [1:0] rsel);
        logic h;
        pad_in = pad; wr_en = we; wr_sel = sel; wr_data = data; rd_sel = rsel;
        for (int i = 0; i < N; i++) begin
            logic ci, cw;
            h  = trig_hit(m_cfg[i][0], m_cfg[i][2:1], pad[i], m_prev[i]);
            ci = we && (sel == 2'(i)) && data[13];
            cw = we && (sel == 2'(i)) && data[14];
            m_is[i] = (m_cfg[i][3] && h) || (m_is[i] && !ci);
            m_ws[i] = (m_cfg[i][5] && h) || (m_ws[i] && !cw);
        end
        m_prev = pad;
        m_pad  = pad;
        if (we) m_cfg[sel] = data[11:0];
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 pend_vec", 32'(pend_vec), 0);
        chk("R1 rd_data", 32'(rd_data), 0);

        // R3 rising edge select on pin 0
        cyc(4'b0000, 1, 2'd0, 16'h001A, 2'd0);
        cyc(4'b0001, 0, 2'd0, 0, 2'd0);
        chk("R3 rise sets", 32'(irq_vec[0]), 1);
        // R7 clear by writing back, input steady
        cyc(4'b0001, 1, 2'd0, 16'h201A, 2'd0);
        chk("R7 cleared", 32'(irq_vec[0]), 0);
        cyc(4'b0000, 0, 2'd0, 0, 2'd0);
        chk("R3 fall ignored by rise select", 32'(pend_vec[0]), 0);
        // R3 falling select
        cyc(4'b0001, 1, 2'd0, 16'h0018, 2'd0);
        cyc(4'b0000, 0, 2'd0, 0, 2'd0);
        chk("R3 fall select", 32'(irq_vec[0]), 1);
        cyc(4'b0000, 1, 2'd0, 16'h201C, 2'd0);
        // R8 edge and clear in the same cycle (both-edge select)
        cyc(4'b0001, 1, 2'd0, 16'h201C, 2'd0);
        chk("R8 set wins", 32'(irq_vec[0]), 1);
        // R3 select 11 never triggers
        cyc(4'b0001, 1, 2'd0, 16'h201E, 2'd0);
        cyc(4'b0000, 0, 2'd0, 0, 2'd0);
        chk("R3 select 11 silent", 32'(pend_vec[0]), 0);

        // R4 level high on pin 1
        cyc(4'b0010, 1, 2'd1, 16'h001B, 2'd1);
        cyc(4'b0010, 0, 2'd1, 0, 2'd1);
        chk("R4 level active", 32'(irq_vec[1]), 1);
        cyc(4'b0010, 1, 2'd1, 16'h201B, 2'd1);
        chk("R4 clear refused while active", 32'(irq_vec[1]), 1);
        cyc(4'b0000, 1, 2'd1, 16'h201B, 2'd1);
        chk("R4 clear after release", 32'(irq_vec[1]), 0);

        // R5/R9 wake without interrupt enable on pin 2
        cyc(4'b0000, 1, 2'd2, 16'h0032, 2'd2);
        cyc(4'b0100, 0, 2'd2, 0, 2'd2);
        chk("R5 no interrupt status", 32'(rd_data[13]), 0);
        chk("R9 wake pending", 32'(pend_vec[2]), 1);
        cyc(4'b0100, 1, 2'd2, 16'h4032, 2'd2);
        chk("R7 wake cleared", 32'(pend_vec[2]), 0);

        // R10/R11/R12 outputs and stored fields on pin 3
        cyc(4'b0000, 1, 2'd3, 16'h0FC0, 2'd3);
        chk("R11 readback", 32'(rd_data), 32'h1FC0);
        chk("R10 pad_oe", 32'(pad_oe), 32'h8);
        chk("R12 other pin untouched", 32'(pad_out[2:0]), 0);

        // random phase
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] p;
            logic [15:0] d;
            p = m_pad ^ 4'($urandom_range(0, 15) & $urandom_range(0, 15));
            d = 16'($urandom) & 16'h7FFF;
            if ($urandom_range(0, 2) != 0) d[4:3] = 2'b11;
            cyc(p, ($urandom_range(0, 4) == 0), 2'($urandom), d, 2'($urandom));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule